// File: doc/BRIEF.md
# Dual-Channel Comparator Code Serializer

This block sits behind two readout channels, each of which ends in three threshold comparators. Once per sampling period, it reduces each channel's comparator vector to a 2-bit amplitude code. Because each comparator threshold is set per channel, the code describes a configurable, non-linear amplitude scale. The block joins the two codes into a 4-bit word and sends that word out on one serial line at four times the sampling rate, so exactly one word leaves per sampling period.

Everything runs on the bit clock. The sampling-rate strobe is a one-cycle pulse that is synchronous to the bit clock and normally repeats every four bit clocks. On each strobe the block captures both comparator vectors at the same moment. Shifting then works only from that captured copy, so the comparator inputs may change freely while a word is in flight.

The serial output is a fixed-rate stream with no valid/ready handshake, and the receiver cannot apply back-pressure. A new word starts on every strobe. When no strobe arrives, the last captured word is sent again. The frame marker shows the receiver where each word begins.

Top module: `cmp_pair_serializer`

## Requirements
- R1: After reset, `ser_dat` and `frame_mark` stay low until the first `frame_stb` has been sampled, whatever the comparator inputs are.
- R2: A channel's 2-bit code equals the number of its comparators that are asserted. Bit 0 of a comparator vector is the lowest threshold. The normal patterns are 000→0, 001→1, 011→2 and 111→3.
- R3: Non-thermometer (bubble) patterns are also coded by counting asserted bits. For example, 010→1, 100→1, 101→2 and 110→2.
- R4: In the bit period that follows the clock edge sampling `frame_stb`, and in the three bit periods after it, `ser_dat` carries channel 0 MSB, channel 0 LSB, channel 1 MSB and channel 1 LSB, in that order.
- R5: `frame_mark` is high only in the bit period that carries the first bit of a word.
- R6: Comparator inputs are sampled only at a strobe edge. Changing them between strobes does not alter the bits being sent.
- R7: A strobe that arrives before four bits have been sent realigns the output. The next bit period carries the first bit of the newly captured word, with `frame_mark` high.
- R8: Once running, if no strobe arrives after the fourth bit, the captured word is sent again from its first bit, with `frame_mark` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (four periods per sampling period) |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle sampling strobe, synchronous to `clk` |
| ch0_cmp | input | 3 | Channel 0 comparator outputs, bit 0 = lowest threshold |
| ch1_cmp | input | 3 | Channel 1 comparator outputs, bit 0 = lowest threshold |
| ser_dat | output | 1 | Serial data bit |
| frame_mark | output | 1 | High during the first bit of each word |

## Verification
Clean thermometer codes are sent with each level on each channel, and the two channels are given different levels. This separates a correct count from a swapped channel order or a reversed bit order. Bubble patterns set bits in a different place than the thermometer pattern with the same count. A priority encoder or highest-bit decoder would therefore give different bits, while a plain count would not. Further frames change the inputs in the middle of a word, leave out the strobe, and pulse the strobe early. These show whether the word is taken from the captured copy, repeated correctly, and realigned.

// File: rtl/cps_pkg.sv
package cps_pkg;
  function automatic int code_bits(input int ncmp);
    return $clog2(ncmp + 1);
  endfunction
endpackage

// File: rtl/cps_count_enc.sv
module cps_count_enc #(
  parameter int NCMP = 3,
  localparam int CW = cps_pkg::code_bits(NCMP)
) (
  input  logic [NCMP-1:0] cmp,
  output logic [CW-1:0]   code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < NCMP; i++) begin
      code = code + CW'(cmp[i]);
    end
  end
endmodule

// File: rtl/cps_frame_ctrl.sv
module cps_frame_ctrl #(
  parameter int FBITS = 4,
  localparam int IW = $clog2(FBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  output logic          run,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(FBITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      idx <= '0;
    end else if (stb) begin
      run <= 1'b1;
      idx <= '0;
    end else if (run) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/cps_word_hold.sv
module cps_word_hold #(
  parameter int FBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FBITS-1:0] din,
  output logic [FBITS-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) word <= '0;
    else if (load) word <= din;
  end
endmodule

// File: rtl/cps_bit_sel.sv
module cps_bit_sel #(
  parameter int FBITS = 4,
  localparam int IW = $clog2(FBITS)
) (
  input  logic             run,
  input  logic [IW-1:0]    idx,
  input  logic [FBITS-1:0] word,
  output logic             bit_o,
  output logic             mark_o
);
  always_comb begin
    bit_o  = run ? word[IW'(FBITS - 1) - idx] : 1'b0;
    mark_o = run && (idx == '0);
  end
endmodule

// File: rtl/cmp_pair_serializer.sv
module cmp_pair_serializer #(
  parameter int NCMP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_stb,
  input  logic [NCMP-1:0] ch0_cmp,
  input  logic [NCMP-1:0] ch1_cmp,
  output logic            ser_dat,
  output logic            frame_mark
);
  localparam int NCH   = 2;
  localparam int CW    = cps_pkg::code_bits(NCMP);
  localparam int FBITS = NCH * CW;
  localparam int IW    = $clog2(FBITS);

  logic [NCMP-1:0]  cmp_arr [NCH];
  logic [CW-1:0]    code_arr[NCH];
  logic [FBITS-1:0] word_d, word_q;
  logic             run;
  logic [IW-1:0]    idx;

  assign cmp_arr[0] = ch0_cmp;
  assign cmp_arr[1] = ch1_cmp;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cps_count_enc #(.NCMP(NCMP)) u_enc (.cmp(cmp_arr[c]), .code(code_arr[c]));
    assign word_d[FBITS-1-c*CW -: CW] = code_arr[c];
  end

  cps_word_hold #(.FBITS(FBITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(frame_stb), .din(word_d), .word(word_q)
  );

  cps_frame_ctrl #(.FBITS(FBITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .run(run), .idx(idx)
  );

  cps_bit_sel #(.FBITS(FBITS)) u_sel (
    .run(run), .idx(idx), .word(word_q), .bit_o(ser_dat), .mark_o(frame_mark)
  );
endmodule

// File: rtl/cmp_pair_serializer_chk.sv
module cmp_pair_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb,
  input logic [2:0] ch0_cmp,
  input logic [2:0] ch1_cmp,
  input logic       ser_dat,
  input logic       frame_mark
);
  logic       seen_q;
  logic [1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pos_q  <= '0;
    end else if (frame_stb) begin
      seen_q <= 1'b1;
      pos_q  <= '0;
    end else begin
      pos_q  <= 2'(pos_q + 2'd1);
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!ser_dat && !frame_mark));

  // R5
  mark_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark == (seen_q && pos_q == 2'd0));

  // R4
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> ser_dat == ($countones($past(ch0_cmp)) >= 2));

  // R2
  ch1_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && pos_q == 2'd3 && !$past(frame_stb, 3) && $past(frame_stb, 4))
      |-> ser_dat == (($countones($past(ch1_cmp, 4)) % 2) == 1));

  // R8
  repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && pos_q == 2'd0 && !$past(frame_stb)) |-> ser_dat == $past(ser_dat, 4));
endmodule

bind cmp_pair_serializer cmp_pair_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ch0_cmp(ch0_cmp),
  .ch1_cmp(ch1_cmp), .ser_dat(ser_dat), .frame_mark(frame_mark)
);

// File: tb/cmp_pair_serializer_test.sv
module cmp_pair_serializer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [2:0] ch0_cmp = '0;
  logic [2:0] ch1_cmp = '0;
  logic       ser_dat, frame_mark;
  int         n_chk = 0;
  int         n_err = 0;

  always #4 clk = ~clk;

  cmp_pair_serializer uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] cnt3(input logic [2:0] v);
    return 2'(v[0]) + 2'(v[1]) + 2'(v[2]);
  endfunction

  // one strobe, four bit periods sampled mid-cycle
  task automatic frame(input logic [2:0] a, input logic [2:0] b,
                       output logic [3:0] bits, output logic [3:0] marks);
    @(negedge clk); ch0_cmp = a; ch1_cmp = b; frame_stb = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); frame_stb = 1'b0;
      bits[3-i] = ser_dat; marks[3-i] = frame_mark;
    end
  endtask

  task automatic t_reset;
    ch0_cmp = 3'b111; ch1_cmp = 3'b111;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 ser_dat idle", ser_dat, 0);
      chk("R1 frame_mark idle", frame_mark, 0);
    end
  endtask

  task automatic t_pair(input string req, input logic [2:0] a, input logic [2:0] b);
    logic [3:0] bits, marks;
    frame(a, b, bits, marks);
    chk(req, bits, {cnt3(a), cnt3(b)});
    chk("R5 marker", marks, 4'b1000);
  endtask

  task automatic t_hold;
    logic [3:0] bits;
    @(negedge clk); ch0_cmp = 3'b011; ch1_cmp = 3'b111; frame_stb = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); frame_stb = 1'b0;
      bits[3-i] = ser_dat;
      ch0_cmp = 3'(i * 3 + 4); ch1_cmp = 3'(i + 2);
    end
    chk("R6 inputs changed mid-word", bits, 4'b1011);
  endtask

  task automatic t_repeat;
    logic [3:0] bits, marks, b2, m2;
    frame(3'b001, 3'b011, bits, marks);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); b2[3-i] = ser_dat; m2[3-i] = frame_mark;
    end
    chk("R8 repeated word", b2, 4'b0110);
    chk("R8 repeated marker", m2, 4'b1000);
  endtask

  task automatic t_realign;
    @(negedge clk); ch0_cmp = 3'b111; ch1_cmp = 3'b000; frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
    @(negedge clk);
    ch0_cmp = 3'b001; ch1_cmp = 3'b111; frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
    chk("R7 realign first bit", ser_dat, 0);
    chk("R7 realign marker", frame_mark, 1);
    @(negedge clk); chk("R7 realign bit1", ser_dat, 1);
    @(negedge clk); chk("R7 realign bit2", ser_dat, 1);
    chk("R7 no marker mid-word", frame_mark, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pair("R2 R4 000/111", 3'b000, 3'b111);
        t_pair("R2 R4 001/011", 3'b001, 3'b011);
        t_pair("R2 R4 011/001", 3'b011, 3'b001);
        t_pair("R2 R4 111/000", 3'b111, 3'b000);
        t_pair("R3 bubble 010/101", 3'b010, 3'b101);
        t_pair("R3 bubble 110/100", 3'b110, 3'b100);
        t_hold();
        t_repeat();
        t_realign();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule